// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit virtual address into a 34-bit physical address by reading page table entries from memory, one level at a time. A request carries the virtual address, the kind of access, the privilege mode, two permission modifiers (make-executable-readable and supervisor-may-touch-user-pages), the base address of the root table and the level the walk starts at. Each level costs one 4-byte read on a single-outstanding request/response memory port.

The walk ends in one of two ways. It either yields a success record (physical address, the leaf entry, the address that entry was read from, the level it was found at and a sticky global flag) or a 3-bit fault code. Caching of translations and write-back of accessed/dirty bits are left to the surrounding logic.

Entry layout used throughout: bit 0 valid (V), bit 1 readable (R), bit 2 writable (W), bit 3 executable (X), bit 4 user (U), bit 5 global (G), bits 7:6 accessed/dirty (not interpreted), bits 31:10 the 22-bit physical page number (PPN). Virtual address: bits 11:0 page offset, bits 21:12 level-0 index, bits 31:22 level-1 index.

Top module: `ptw_walker`

## Requirements
- R1: The entry address at level L is the current table base plus (the virtual page number shifted right by 10·L, low 10 bits kept) times 4. It is reported as 34 bits, and its low 32 bits drive `mem_req_addr`. The request address stays stable until it is accepted.
- R2: Exactly one read is issued per level visited. A pointer entry (V=1, R=W=X=0) found above level 0 makes the next base {PPN, 12'h000} and lowers the level by one.
- R3: A read that returns `mem_rsp_err`=1 ends the walk with fault code 1 (access).
- R4: An entry with V=0, or with W=1 and R=0, ends the walk with fault code 2 (bad entry). An address never written in memory reads as zero and is therefore bad.
- R5: A pointer entry at level 0 ends the walk with fault code 2 and issues no further read.
- R6: `res_global` is the OR of the G bits of all entries read during the walk.
- R7: A leaf fails with fault code 3 when the access kind is not allowed: load (`req_acc`=0) needs R, or X with `req_mxr`=1; store (1) needs W; fetch (2) needs X. User mode (`req_priv`=0) needs U=1. Supervisor mode (1) on a U=1 page is allowed only for load/store with `req_sum`=1.
- R8: A leaf at level 1 whose PPN bits 9:0 are not all zero ends the walk with fault code 4 (misaligned).
- R9: On success (fault 0), `res_paddr` = {resolved PPN, virtual bits 11:0}. At level 1 the low 10 PPN bits are replaced by virtual bits 21:12. `res_pte`, `res_pte_addr` and `res_level` describe the leaf.
- R10: `done` is high for exactly one cycle per accepted request. `req_ready` is high only while no walk is in progress.
- R11: With `req_level`=0 the walk begins at level 0 at the given root and takes one read.
- R12: After reset, `req_ready`=1, `done`=0 and `mem_req_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle if valid |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_priv | input | 1 | 0 user, 1 supervisor |
| req_mxr | input | 1 | Executable pages readable by loads |
| req_sum | input | 1 | Supervisor may load/store user pages |
| req_root | input | 34 | Base address of the starting table |
| req_level | input | 1 | Starting level |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Entry address (low 32 bits) |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry value |
| mem_rsp_err | input | 1 | Read failed |
| done | output | 1 | Result valid, one cycle |
| res_fault | output | 3 | 0 none, 1 access, 2 bad entry, 3 permission, 4 misaligned |
| res_paddr | output | 34 | Physical address |
| res_pte | output | 32 | Leaf entry |
| res_pte_addr | output | 34 | Address of the leaf entry |
| res_level | output | 1 | Level of the leaf |
| res_global | output | 1 | Sticky global flag |

## Verification
Faults that only arise on the second level are the hardest to provoke: a pointer at level 0, a read error after a successful descent, and a global bit that must survive from the pointer entry into a leaf whose own G is clear. The bench clears its memory image before each scenario. It then plants a chain of entries at the exact addresses a given virtual address indexes, so each walk is steered through both levels before the chosen condition appears. A root above the 32-bit port range checks that the port address is truncated while the reported entry address is not.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int unsigned VA_W   = 32;
    localparam int unsigned OFS_W  = 12;
    localparam int unsigned IDX_W  = 10;
    localparam int unsigned LEVELS = 2;
    localparam int unsigned PTE_W  = 32;
    localparam int unsigned FLG_W  = 10;
    localparam int unsigned MEM_AW = 32;

    localparam int unsigned PPN_W  = PTE_W - FLG_W;
    localparam int unsigned PA_W   = PPN_W + OFS_W;
    localparam int unsigned VPN_W  = VA_W - OFS_W;
    localparam int unsigned LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1;
    localparam int unsigned PTE_SH = $clog2(PTE_W / 8);

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_ACCESS = 3'd1,
        FLT_BADPTE = 3'd2,
        FLT_PERM   = 3'd3,
        FLT_ALIGN  = 3'd4,
        FLT_UPDATE = 3'd5
    } fault_e;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_WAIT  = 2'd2,
        S_DONE  = 2'd3
    } walk_state_e;

    typedef struct packed {
        logic d;
        logic a;
        logic g;
        logic u;
        logic x;
        logic w;
        logic r;
        logic v;
    } pte_flags_t;

    function automatic pte_flags_t flags_of(input logic [7:0] raw);
        return pte_flags_t'(raw);
    endfunction

endpackage

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
    import ptw_pkg::*;
(
    input  logic [7:0] flag_bits,
    input  logic [1:0] acc,
    input  logic       priv_super,
    input  logic       mxr,
    input  logic       sum,
    output logic       is_bad,
    output logic       is_pointer,
    output logic       perm_ok
);

    pte_flags_t f;
    acc_e       kind;
    logic       kind_ok;
    logic       mode_ok;

    assign f    = flags_of(flag_bits);
    assign kind = acc_e'(acc);

    always_comb begin
        is_bad     = !f.v || (f.w && !f.r);
        is_pointer = f.v && !f.r && !f.w && !f.x;

        case (kind)
            ACC_LOAD:  kind_ok = f.r || (f.x && mxr);
            ACC_STORE: kind_ok = f.w;
            ACC_FETCH: kind_ok = f.x;
            default:   kind_ok = 1'b0;
        endcase

        if (priv_super)
            mode_ok = !f.u || (sum && (kind != ACC_FETCH));
        else
            mode_ok = f.u;

        perm_ok = kind_ok && mode_ok;
    end

endmodule

// File: rtl/ptw_leaf_map.sv
module ptw_leaf_map #(
    parameter int unsigned PPN_W = 22,
    parameter int unsigned VPN_W = 20,
    parameter int unsigned IDX_W = 10,
    parameter int unsigned LVL_W = 1
) (
    input  logic [PPN_W-1:0] ppn,
    input  logic [VPN_W-1:0] vpn,
    input  logic [LVL_W-1:0] lvl,
    output logic             misaligned,
    output logic [PPN_W-1:0] ppn_out
);

    logic [PPN_W-1:0] low_mask;
    logic [PPN_W-1:0] vpn_ext;

    for (genvar i = 0; i < PPN_W; i++) begin : g_mask
        assign low_mask[i] = (i < (int'(lvl) * IDX_W));
    end

    assign vpn_ext    = PPN_W'(vpn);
    assign misaligned = |(ppn & low_mask);
    assign ppn_out    = (ppn & ~low_mask) | (vpn_ext & low_mask);

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int unsigned P_VA_W  = VA_W,
    parameter int unsigned P_PA_W  = PA_W,
    parameter int unsigned P_PTE_W = PTE_W,
    parameter int unsigned P_MEMAW = MEM_AW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [P_VA_W-1:0]  req_vaddr,
    input  logic [1:0]         req_acc,
    input  logic               req_priv,
    input  logic               req_mxr,
    input  logic               req_sum,
    input  logic [P_PA_W-1:0]  req_root,
    input  logic [LVL_W-1:0]   req_level,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [P_MEMAW-1:0] mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [P_PTE_W-1:0] mem_rsp_data,
    input  logic               mem_rsp_err,
    output logic               done,
    output logic [2:0]         res_fault,
    output logic [P_PA_W-1:0]  res_paddr,
    output logic [P_PTE_W-1:0] res_pte,
    output logic [P_PA_W-1:0]  res_pte_addr,
    output logic [LVL_W-1:0]   res_level,
    output logic               res_global
);

    localparam int unsigned L_VPN_W = P_VA_W - OFS_W;
    localparam int unsigned L_PPN_W = P_PTE_W - FLG_W;

    walk_state_e        state;
    logic [P_VA_W-1:0]  vaddr_q;
    logic [1:0]         acc_q;
    logic               priv_q;
    logic               mxr_q;
    logic               sum_q;
    logic [P_PA_W-1:0]  base_q;
    logic [LVL_W-1:0]   lvl_q;
    logic               glob_q;

    fault_e             fault_q;
    logic [P_PA_W-1:0]  paddr_q;
    logic [P_PTE_W-1:0] pte_q;
    logic [P_PA_W-1:0]  pte_addr_q;
    logic [LVL_W-1:0]   level_q;
    logic               gflag_q;

    // Entry address for the current level
    logic [L_VPN_W-1:0] vpn_cur;
    logic [L_VPN_W-1:0] vpn_shift;
    logic [IDX_W-1:0]   idx;
    logic [P_PA_W-1:0]  pte_addr;

    assign vpn_cur   = vaddr_q[P_VA_W-1:OFS_W];
    assign vpn_shift = vpn_cur >> (int'(lvl_q) * IDX_W);
    assign idx       = vpn_shift[IDX_W-1:0];
    assign pte_addr  = base_q + P_PA_W'({idx, {PTE_SH{1'b0}}});

    // Response decode
    logic [L_PPN_W-1:0] rsp_ppn;
    logic [L_PPN_W-1:0] mapped_ppn;
    logic               rsp_g;
    logic               glob_next;
    logic               pte_bad;
    logic               pte_ptr;
    logic               perm_ok;
    logic               misaligned;

    assign rsp_ppn   = mem_rsp_data[P_PTE_W-1:FLG_W];
    assign rsp_g     = flags_of(mem_rsp_data[7:0]).g;
    assign glob_next = glob_q || (rsp_g && !mem_rsp_err);

    ptw_pte_check u_check (
        .flag_bits  (mem_rsp_data[7:0]),
        .acc        (acc_q),
        .priv_super (priv_q),
        .mxr        (mxr_q),
        .sum        (sum_q),
        .is_bad     (pte_bad),
        .is_pointer (pte_ptr),
        .perm_ok    (perm_ok)
    );

    ptw_leaf_map #(
        .PPN_W (L_PPN_W),
        .VPN_W (L_VPN_W),
        .IDX_W (IDX_W),
        .LVL_W (LVL_W)
    ) u_map (
        .ppn        (rsp_ppn),
        .vpn        (vpn_cur),
        .lvl        (lvl_q),
        .misaligned (misaligned),
        .ppn_out    (mapped_ppn)
    );

    fault_e step_fault;
    logic   step_descend;

    always_comb begin
        step_fault   = FLT_NONE;
        step_descend = 1'b0;
        if (mem_rsp_err) begin
            step_fault = FLT_ACCESS;
        end else if (pte_bad) begin
            step_fault = FLT_BADPTE;
        end else if (pte_ptr) begin
            if (lvl_q == '0)
                step_fault = FLT_BADPTE;
            else
                step_descend = 1'b1;
        end else if (!perm_ok) begin
            step_fault = FLT_PERM;
        end else if (misaligned) begin
            step_fault = FLT_ALIGN;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            vaddr_q    <= '0;
            acc_q      <= '0;
            priv_q     <= 1'b0;
            mxr_q      <= 1'b0;
            sum_q      <= 1'b0;
            base_q     <= '0;
            lvl_q      <= '0;
            glob_q     <= 1'b0;
            fault_q    <= FLT_NONE;
            paddr_q    <= '0;
            pte_q      <= '0;
            pte_addr_q <= '0;
            level_q    <= '0;
            gflag_q    <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        vaddr_q <= req_vaddr;
                        acc_q   <= req_acc;
                        priv_q  <= req_priv;
                        mxr_q   <= req_mxr;
                        sum_q   <= req_sum;
                        base_q  <= req_root;
                        lvl_q   <= req_level;
                        glob_q  <= 1'b0;
                        state   <= S_ISSUE;
                    end
                end
                S_ISSUE: begin
                    if (mem_req_ready)
                        state <= S_WAIT;
                end
                S_WAIT: begin
                    if (mem_rsp_valid) begin
                        glob_q <= glob_next;
                        if (step_descend) begin
                            base_q <= {rsp_ppn, {OFS_W{1'b0}}};
                            lvl_q  <= lvl_q - LVL_W'(1);
                            state  <= S_ISSUE;
                        end else begin
                            fault_q    <= step_fault;
                            paddr_q    <= {mapped_ppn, vaddr_q[OFS_W-1:0]};
                            pte_q      <= mem_rsp_data;
                            pte_addr_q <= pte_addr;
                            level_q    <= lvl_q;
                            gflag_q    <= glob_next;
                            state      <= S_DONE;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign req_ready     = (state == S_IDLE);
    assign mem_req_valid = (state == S_ISSUE);
    assign mem_req_addr  = pte_addr[P_MEMAW-1:0];
    assign done          = (state == S_DONE);
    assign res_fault     = fault_q;
    assign res_paddr     = paddr_q;
    assign res_pte       = pte_q;
    assign res_pte_addr  = pte_addr_q;
    assign res_level     = level_q;
    assign res_global    = gflag_q;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_ready && !done); // R10
    AST_ISSUE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R1
    AST_SINGLE_READ: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && mem_req_ready |=> !mem_req_valid); // R2
    AST_GLOBAL_STICKY: assert property (@(posedge clk) disable iff (rst)
        glob_q && !(req_valid && req_ready) |=> glob_q); // R6
    AST_L0_TERMINAL: assert property (@(posedge clk) disable iff (rst)
        (state == S_WAIT) && mem_rsp_valid && (lvl_q == '0) |=> done); // R5
    AST_SUPER_MERGE: assert property (@(posedge clk) disable iff (rst)
        done && (res_fault == FLT_NONE) && (res_level != '0)
        |-> res_paddr[OFS_W+IDX_W-1:OFS_W] == vaddr_q[OFS_W+IDX_W-1:OFS_W]); // R9

endmodule

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic        req_priv = 1'b0;
    logic        req_mxr = 1'b0;
    logic        req_sum = 1'b0;
    logic [33:0] req_root = '0;
    logic [0:0]  req_level = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        mem_rsp_err = 1'b0;
    logic        done;
    logic [2:0]  res_fault;
    logic [33:0] res_paddr;
    logic [31:0] res_pte;
    logic [33:0] res_pte_addr;
    logic [0:0]  res_level;
    logic        res_global;

    always #2.5 clk = ~clk;

    ptw_walker dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_acc(req_acc), .req_priv(req_priv), .req_mxr(req_mxr), .req_sum(req_sum),
        .req_root(req_root), .req_level(req_level),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .done(done), .res_fault(res_fault), .res_paddr(res_paddr), .res_pte(res_pte),
        .res_pte_addr(res_pte_addr), .res_level(res_level), .res_global(res_global)
    );

    typedef struct {
        logic [2:0]  fault;
        logic [33:0] pa;
        logic [31:0] pte;
        logic [33:0] pte_addr;
        logic        lvl;
        logic        g;
        int          nreads;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] mem [logic [31:0]];
    bit          err_at [logic [31:0]];
    int          n_chk = 0;
    int          n_fail = 0;
    int          reads_seen = 0;
    int          lat_sel = 0;

    localparam logic [33:0] ROOT = 34'h0_0010_0000;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic report_and_end();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    function automatic logic [33:0] loc(input logic [33:0] base, input logic [31:0] va, input int l);
        logic [31:0] ix;
        ix = ((va >> 12) >> (l * 10)) & 32'h3FF;
        return base + {22'b0, ix[9:0], 2'b00};
    endfunction

    function automatic logic [31:0] mkpte(input logic [21:0] ppn, input logic [7:0] fl);
        return {ppn, 2'b00, fl};
    endfunction

    // Reference model written from the requirements
    function automatic exp_t model(input logic [31:0] va, input logic [1:0] acc, input logic sup,
                                   input logic mxr, input logic sum, input logic [33:0] root,
                                   input int lv, input string tag);
        exp_t e;
        logic [33:0] base;
        logic [33:0] a;
        logic [31:0] p;
        int l;
        bit ok;
        e.fault = 0; e.pa = '0; e.pte = '0; e.pte_addr = '0; e.lvl = 0; e.g = 0;
        e.nreads = 0; e.tag = tag;
        base = root; l = lv;
        for (int step = 0; step < 2; step++) begin
            a = loc(base, va, l);
            e.nreads++;
            e.pte_addr = a;
            e.lvl = l[0];
            if (err_at.exists(a[31:0])) begin e.fault = 1; return e; end
            p = mem.exists(a[31:0]) ? mem[a[31:0]] : 32'h0;
            e.pte = p;
            e.g = e.g | p[5];
            if (!p[0] || (p[2] && !p[1])) begin e.fault = 2; return e; end
            if (!p[1] && !p[2] && !p[3]) begin
                if (l == 0) begin e.fault = 2; return e; end
                base = {p[31:10], 12'h000};
                l = l - 1;
                continue;
            end
            ok = (acc == 0) ? (p[1] | (p[3] & mxr)) : (acc == 1) ? p[2] : p[3];
            if (sup) begin
                if (p[4] && !(sum && acc != 2)) ok = 0;
            end else if (!p[4]) ok = 0;
            if (!ok) begin e.fault = 3; return e; end
            if (l == 1 && p[19:10] != 0) begin e.fault = 4; return e; end
            e.pa = (l == 1) ? {p[31:20], va[21:12], va[11:0]} : {p[31:10], va[11:0]};
            return e;
        end
        return e;
    endfunction

    task automatic put(input logic [33:0] a, input logic [31:0] d);
        mem[a[31:0]] = d;
    endtask

    task automatic fresh();
        mem.delete();
        err_at.delete();
    endtask

    // Driver: push expectation, present request, wait for result
    task automatic run(input string tag, input logic [31:0] va, input logic [1:0] acc,
                       input logic sup, input logic mxr, input logic sum,
                       input logic [33:0] root, input int lv);
        exp_q.push_back(model(va, acc, sup, mxr, sum, root, lv, tag));
        @(negedge clk);
        chk(req_ready == 1'b1, "R10", "ready while idle", req_ready, 1);
        req_vaddr = va; req_acc = acc; req_priv = sup; req_mxr = mxr; req_sum = sum;
        req_root = root; req_level = lv[0]; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R10", "ready while busy", req_ready, 0);
        wait (exp_q.size() == 0);
        repeat (2) @(negedge clk);
    endtask

    // Memory responder
    initial begin
        logic [31:0] a;
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                repeat (lat_sel % 2) @(negedge clk);
                mem_req_ready = 1'b1;
                a = mem_req_addr;
                @(negedge clk);
                mem_req_ready = 1'b0;
                repeat (lat_sel % 3) @(negedge clk);
                lat_sel++;
                mem_rsp_valid = 1'b1;
                mem_rsp_err   = err_at.exists(a);
                mem_rsp_data  = mem.exists(a) ? mem[a] : 32'h0;
                reads_seen++;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                mem_rsp_err   = 1'b0;
                mem_rsp_data  = '0;
            end
        end
    end

    // Monitor: compare each result against the scoreboard
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (done) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10", "unexpected done", 1, 0);
                end else begin
                    e = exp_q[0];
                    chk(res_fault == e.fault, e.tag, "fault code", res_fault, e.fault);
                    chk(reads_seen == e.nreads, "R2", "reads per walk", reads_seen, e.nreads);
                    if (e.fault == 0) begin
                        chk(res_paddr == e.pa, "R9", "physical address", res_paddr, e.pa);
                        chk(res_pte == e.pte, "R9", "leaf entry", res_pte, e.pte);
                        chk(res_pte_addr == e.pte_addr, "R1", "entry address", res_pte_addr, e.pte_addr);
                        chk(res_level == e.lvl, "R9", "leaf level", res_level, e.lvl);
                        chk(res_global == e.g, "R6", "global flag", res_global, e.g);
                    end
                    reads_seen = 0;
                    void'(exp_q.pop_front());
                end
                @(negedge clk);
                chk(done == 1'b0, "R10", "done width", done, 0);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R10 watchdog expired: actual hung expected finished");
        report_and_end();
    end

    initial begin
        logic [31:0] va;
        logic [33:0] b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R12", "ready after reset", req_ready, 1);
        chk(done == 1'b0, "R12", "done after reset", done, 0);
        chk(mem_req_valid == 1'b0, "R12", "no read after reset", mem_req_valid, 0);

        // 4K page via pointer carrying G; leaf without G (R2, R6, R9)
        fresh(); va = 32'h4040_3123; b0 = {22'h00200, 12'h0};
        put(loc(ROOT, va, 1), mkpte(22'h00200, 8'h21));
        put(loc(b0, va, 0), mkpte(22'h12345, 8'hC7));
        run("R9", va, 2'd0, 1'b1, 1'b0, 1'b0, ROOT, 1);

        // aligned superpage, G on leaf (R9, R6)
        fresh(); va = 32'h8123_4ABC;
        put(loc(ROOT, va, 1), mkpte(22'h0AC00, 8'hE7));
        run("R9", va, 2'd1, 1'b1, 1'b0, 1'b0, ROOT, 1);

        // misaligned superpage (R8)
        fresh(); va = 32'h8123_4ABC;
        put(loc(ROOT, va, 1), mkpte(22'h0AC01, 8'hC7));
        run("R8", va, 2'd0, 1'b1, 1'b0, 1'b0, ROOT, 1);

        // invalid: V=0 (R4)
        fresh(); va = 32'h1234_5678;
        put(loc(ROOT, va, 1), mkpte(22'h00300, 8'hC6));
        run("R4", va, 2'd0, 1'b1, 1'b0, 1'b0, ROOT, 1);

        // invalid: W without R at level 0 (R4)
        fresh(); va = 32'h1234_5678; b0 = {22'h00300, 12'h0};
        put(loc(ROOT, va, 1), mkpte(22'h00300, 8'h01));
        put(loc(b0, va, 0), mkpte(22'h00555, 8'hC5));
        run("R4", va, 2'd0, 1'b1, 1'b0, 1'b0, ROOT, 1);

        // unpopulated entry reads zero (R4)
        fresh(); va = 32'hFFC0_1000;
        run("R4", va, 2'd0, 1'b1, 1'b0, 1'b0, ROOT, 1);

        // pointer at level 0 (R5)
        fresh(); va = 32'h0040_2000; b0 = {22'h00400, 12'h0};
        put(loc(ROOT, va, 1), mkpte(22'h00400, 8'h01));
        put(loc(b0, va, 0), mkpte(22'h00500, 8'h01));
        run("R5", va, 2'd0, 1'b1, 1'b0, 1'b0, ROOT, 1);

        // access error at level 1 (R3)
        fresh(); va = 32'h7000_0000;
        err_at[loc(ROOT, va, 1)] = 1'b1;
        run("R3", va, 2'd0, 1'b1, 1'b0, 1'b0, ROOT, 1);

        // access error at level 0 after descent (R3)
        fresh(); va = 32'h7000_5000; b0 = {22'h00600, 12'h0};
        put(loc(ROOT, va, 1), mkpte(22'h00600, 8'h01));
        err_at[loc(b0, va, 0)] = 1'b1;
        run("R3", va, 2'd0, 1'b1, 1'b0, 1'b0, ROOT, 1);

        // permission cases on a 4K leaf (R7)
        va = 32'h2000_7444; b0 = {22'h00700, 12'h0};
        fresh(); put(loc(ROOT, va, 1), mkpte(22'h00700, 8'h01));
        put(loc(b0, va, 0), mkpte(22'h00ABC, 8'h43));
        run("R7", va, 2'd1, 1'b1, 1'b0, 1'b0, ROOT, 1);   // store to read-only
        put(loc(b0, va, 0), mkpte(22'h00ABC, 8'hC7));
        run("R7", va, 2'd1, 1'b1, 1'b0, 1'b0, ROOT, 1);   // store allowed
        run("R7", va, 2'd0, 1'b0, 1'b0, 1'b0, ROOT, 1);   // user on supervisor page
        put(loc(b0, va, 0), mkpte(22'h00ABC, 8'hD7));
        run("R7", va, 2'd0, 1'b1, 1'b0, 1'b0, ROOT, 1);   // supervisor on user page, sum=0
        run("R7", va, 2'd0, 1'b1, 1'b0, 1'b1, ROOT, 1);   // sum=1 load allowed
        put(loc(b0, va, 0), mkpte(22'h00ABC, 8'hDF));
        run("R7", va, 2'd2, 1'b1, 1'b0, 1'b1, ROOT, 1);   // supervisor fetch from user page
        put(loc(b0, va, 0), mkpte(22'h00ABC, 8'hC9));
        run("R7", va, 2'd0, 1'b1, 1'b0, 1'b0, ROOT, 1);   // exec-only load, mxr=0
        run("R7", va, 2'd0, 1'b1, 1'b1, 1'b0, ROOT, 1);   // exec-only load, mxr=1
        put(loc(b0, va, 0), mkpte(22'h00ABC, 8'hD9));
        run("R7", va, 2'd2, 1'b0, 1'b0, 1'b0, ROOT, 1);   // user fetch allowed

        // start at level 0 (R11)
        fresh(); va = 32'h0000_9ABC; b0 = 34'h0_0030_0000;
        put(loc(b0, va, 0), mkpte(22'h01234, 8'hC7));
        run("R11", va, 2'd0, 1'b1, 1'b0, 1'b0, b0, 0);

        // root above the 32-bit port range (R1)
        fresh(); va = 32'hC080_0321; b0 = 34'h2_0040_0000;
        put(loc(b0, va, 1), mkpte(22'h3FC00, 8'hC7));
        run("R1", va, 2'd0, 1'b1, 1'b0, 1'b0, b0, 1);

        report_and_end();
    end

endmodule